// File: doc/BRIEF.md
# I2C Block-Access Status Target

This block is an I2C target that answers at one 7-bit device address, supplied on an input port. After a START it shifts in the address byte and compares it. On a match it serves either a block read or a block write against a small register file. The register file is addressed through an internal byte pointer. No register-offset byte is sent on the bus.

Two status bytes sit at the bottom of the file and are read-only. One packs the per-channel signal-detect flags and the other packs the per-channel receiver-detect results. Both are taken live from input ports. Above them sit `N_CTRL` writable control bytes, which are presented on an output bus.

A write transaction discards the first data byte after the address as a filler. Each later byte lands at the pointer, and the pointer advances by one per byte. When the write transaction ends, the pointer goes back to 0. A read transaction starts at the current pointer and advances it after every byte.

Top module: `i2c_stat_target`

## Requirements
- R1: A transfer starts only after a START. The first byte is a 7-bit address in bits 7:1 and a direction bit in bit 0 (1 = read). On an address mismatch the target never pulls SDA and ignores the bus until the next START.
- R2: Every byte, in either direction, travels most significant bit first.
- R3: The target acknowledges each byte it receives in a transaction that matches its address. It does so by pulling SDA low over the whole high phase of the ninth clock.
- R4: In a write transaction the first data byte after the address is acknowledged and then discarded. It is never stored.
- R5: Each write data byte after the filler goes to the byte at the pointer, and the pointer then advances. Bytes 0 and 1 are read-only, so a write to them is dropped but still advances the pointer. Byte 2+k appears on `ctrl_q[8k+7:8k]`, and all control bytes reset to 0.
- R6: When a write transaction ends, whether by STOP or by a repeated START, the pointer returns to 0.
- R7: A read starts at the current pointer and advances the pointer after each byte. The pointer wraps from the last byte back to 0.
- R8: SDA is released during the acknowledge slot that the controller owns. A controller ACK (SDA low) makes the target send the next byte. A controller NACK (SDA high) ends the read.
- R9: Byte 0 holds the signal-detect flags. For channel i, bit 7-2i is `sig_a[i]` and bit 6-2i is `sig_b[i]`.
- R10: Byte 1 holds the receiver-detect results, using the same bit mapping as R9 with `rxd_a` and `rxd_b`. While `rxd_valid` is low, byte 1 reads 0x00.
- R11: While the target drives read data, SDA changes only while SCL is low.
- R12: A STOP or a START at any point returns the target to idle with SDA released. After reset SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_addr | input | 7 | Device address to match |
| sig_a | input | 4 | Signal-detect flags, A side of channels 0..3 |
| sig_b | input | 4 | Signal-detect flags, B side of channels 0..3 |
| rxd_a | input | 4 | Receiver-detect results, A side |
| rxd_b | input | 4 | Receiver-detect results, B side |
| rxd_valid | input | 1 | A receiver-detect cycle has completed |
| ctrl_q | output | 8*N_CTRL | Control bytes; byte 2+k at bits 8k+7:8k |

## Verification
The bench writes a block after a read has left the pointer at 3. A design that did not honour the current pointer, or that stored the filler, would show 0xEE in the wrong control byte. It then writes through the two read-only bytes and reads five bytes, so the read wraps past the end. A design with a bad pointer reset or a bad wrap returns the bytes in the wrong order. A repeated START during a write is followed directly by a read, which exposes a design that clears the pointer only on STOP. The status patterns are asymmetric, so reversed channel order or LSB-first shifting shows up as a wrong byte. A STOP in the middle of the address byte and a header on the wrong address both check that the target stays silent.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int CHANS = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACKA, S_WR, S_ACKW, S_RD, S_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_p  <= scl_ff[1];
      sda_p  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/stat_ctrl_regs.sv
module stat_ctrl_regs
  import i2c_stat_pkg::*;
#(
  parameter int N_CTRL = 2,
  parameter int PTR_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [PTR_W-1:0]      rd_addr,
  output logic [7:0]            rd_data,
  input  logic [CHANS-1:0]      sig_a,
  input  logic [CHANS-1:0]      sig_b,
  input  logic [CHANS-1:0]      rxd_a,
  input  logic [CHANS-1:0]      rxd_b,
  input  logic                  rxd_valid,
  output logic [8*N_CTRL-1:0]   ctrl_q
);
  logic [7:0] sig_byte, rxd_byte;
  logic [7:0] ctrl_mem [N_CTRL];

  for (genvar i = 0; i < CHANS; i++) begin : g_map
    assign sig_byte[7-2*i] = sig_a[i];
    assign sig_byte[6-2*i] = sig_b[i];
    assign rxd_byte[7-2*i] = rxd_a[i];
    assign rxd_byte[6-2*i] = rxd_b[i];
  end

  for (genvar k = 0; k < N_CTRL; k++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst)
        ctrl_mem[k] <= 8'h00;
      else if (wr_en && wr_addr == PTR_W'(k + 2))
        ctrl_mem[k] <= wr_data;
    end
    assign ctrl_q[8*k +: 8] = ctrl_mem[k];
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == PTR_W'(0))
      rd_data = sig_byte;
    else if (rd_addr == PTR_W'(1))
      rd_data = rxd_valid ? rxd_byte : 8'h00;
    for (int k = 0; k < N_CTRL; k++)
      if (rd_addr == PTR_W'(k + 2)) rd_data = ctrl_mem[k];
  end

  // R5
  ro_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < PTR_W'(2)) |=> $stable(ctrl_q));
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_stat_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  tgt_state_e       state;
  logic [3:0]       cnt;
  logic [7:0]       shreg;
  logic [6:0]       tx;
  logic             filler, wr_txn;
  logic [PTR_W-1:0] ptr_nxt;
  logic             bus_evt;

  assign ptr_nxt = (ptr == PTR_W'(NREG - 1)) ? '0 : ptr + PTR_W'(1);
  assign bus_evt = start_det | stop_det;
  assign wr_data = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= 4'd0;
      shreg   <= 8'h00;
      tx      <= 7'h00;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      filler  <= 1'b0;
      wr_txn  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_evt) begin
        state  <= start_det ? S_ADDR : S_IDLE;
        cnt    <= 4'd0;
        sda_oe <= 1'b0;
        wr_txn <= 1'b0;
        if (wr_txn) ptr <= '0;
      end else begin
        unique case (state)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (state == S_ADDR) begin
                if (shreg[7:1] == dev_addr) begin
                  sda_oe <= 1'b1;
                  state  <= S_ACKA;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= S_ACKW;
                if (!filler) begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  ptr     <= ptr_nxt;
                end
                filler <= 1'b0;
              end
            end
          end
          S_ACKA: if (scl_fall) begin
            cnt <= 4'd0;
            if (shreg[0]) begin
              tx     <= rd_data[6:0];
              sda_oe <= ~rd_data[7];
              state  <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              filler <= 1'b1;
              wr_txn <= 1'b1;
              state  <= S_WR;
            end
          end
          S_ACKW: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= 4'd0;
            state  <= S_WR;
          end
          S_RD: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              ptr    <= ptr_nxt;
              state  <= S_RACK;
            end else begin
              sda_oe <= ~tx[6];
              tx     <= {tx[5:0], 1'b0};
              cnt    <= cnt + 4'd1;
            end
          end
          S_RACK: begin
            if (scl_rise && sda_s) begin
              state <= S_IDLE;
            end else if (scl_fall) begin
              tx     <= rd_data[6:0];
              sda_oe <= ~rd_data[7];
              cnt    <= 4'd0;
              state  <= S_RD;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R11
  sda_low_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(bus_evt)) |-> !scl_s);

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == S_ACKA || state == S_ACKW) && scl_s && !bus_evt) |-> sda_oe);

  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && state == S_IDLE));

  // R6
  ptr_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_evt && wr_txn) |=> (ptr == '0));

  // R8
  master_slot_free_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RACK) |-> !sda_oe);
endmodule

// File: rtl/i2c_stat_target.sv
module i2c_stat_target
  import i2c_stat_pkg::*;
#(
  parameter int N_CTRL = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic [6:0]          dev_addr,
  input  logic [CHANS-1:0]    sig_a,
  input  logic [CHANS-1:0]    sig_b,
  input  logic [CHANS-1:0]    rxd_a,
  input  logic [CHANS-1:0]    rxd_b,
  input  logic                rxd_valid,
  output logic [8*N_CTRL-1:0] ctrl_q
);
  localparam int NREG  = N_CTRL + 2;
  localparam int PTR_W = $clog2(NREG);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] ptr, wr_addr;
  logic             wr_en;
  logic [7:0]       wr_data, rd_data;

  i2c_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_engine #(.NREG(NREG), .PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .dev_addr(dev_addr),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  stat_ctrl_regs #(.N_CTRL(N_CTRL), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .sig_a(sig_a), .sig_b(sig_b),
    .rxd_a(rxd_a), .rxd_b(rxd_b), .rxd_valid(rxd_valid), .ctrl_q(ctrl_q)
  );
endmodule

// File: tb/test_i2c_stat_target.sv
`timescale 1ns/1ps
module test_i2c_stat_target;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, msda = 1'b1;
  logic sda_oe;
  logic [3:0] sig_a = 4'h0, sig_b = 4'h0, rxd_a = 4'h0, rxd_b = 4'h0;
  logic rxd_valid = 1'b0;
  logic [15:0] ctrl_q;
  wire sda_line = msda & ~sda_oe;

  int nchk = 0, nerr = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_q[$];

  always #4 clk = ~clk;

  i2c_stat_target i_i2c_stat_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_addr(ADDR), .sig_a(sig_a), .sig_b(sig_b), .rxd_a(rxd_a),
    .rxd_b(rxd_b), .rxd_valid(rxd_valid), .ctrl_q(ctrl_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] pack_ch(input logic [3:0] a, input logic [3:0] b);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[7-2*i] = a[i];
      r[6-2*i] = b[i];
    end
    return r;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wt(Q); scl = 1'b1; wt(Q); msda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; wt(Q); scl = 1'b1; wt(Q); msda = 1'b1; wt(Q);
  endtask

  task automatic wbit(input logic b);
    msda = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
  endtask

  // returns the line level; low only if held low at mid and late high phase
  task automatic rbit(output logic b, output bit unstable);
    logic s1, s2;
    msda = 1'b1; wt(Q); scl = 1'b1; wt(Q); s1 = sda_line; wt(Q - 1); s2 = sda_line;
    wt(1); scl = 1'b0; wt(Q);
    b = s1 | s2;
    unstable = (s1 != s2);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    bit u;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ack, u);
  endtask

  // driver: push expectation, clock a byte out, hand it to the monitor
  task automatic rd(input logic [7:0] expv, input string tag, input logic nack);
    logic [7:0] d;
    logic b;
    bit u, any_u;
    logic oe_seen;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    any_u = 0;
    for (int i = 7; i >= 0; i--) begin
      rbit(b, u);
      d[i] = b;
      any_u |= u;
    end
    chk(!any_u, "R11 read data stable while SCL high", any_u, 0);
    msda = nack; wt(Q); scl = 1'b1; wt(Q); oe_seen = sda_oe; wt(Q); scl = 1'b0; wt(Q);
    chk(oe_seen == 1'b0, "R8 SDA released in controller ack slot", oe_seen, 0);
    obs_q.push_back(d);
  endtask

  // monitor: pops and compares as the design produces bytes
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        logic [7:0] e, o;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        o = obs_q.pop_front();
        chk(o == e, t, o, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] stat0;
    wt(5);
    rst = 1'b0;
    wt(5);
    chk(sda_oe == 1'b0, "R12 SDA released after reset", sda_oe, 0);
    chk(ctrl_q == 16'h0000, "R5 control bytes reset to zero", ctrl_q, 0);

    // R1: matching address clocked without a START
    wbyte({ADDR, 1'b0}, ack);
    chk(ack == 1'b1, "R1 no response without START", ack, 1);
    bus_stop();

    // R1: wrong address, then a further byte: both unanswered
    bus_start();
    wbyte({7'h11, 1'b0}, ack);
    chk(ack == 1'b1, "R1 wrong address not acknowledged", ack, 1);
    wbyte(8'h00, ack);
    chk(ack == 1'b1, "R1 stays idle after mismatch", ack, 1);
    bus_stop();

    sig_a = 4'b0101; sig_b = 4'b0011;
    stat0 = pack_ch(sig_a, sig_b);   // 0xD8

    // R9 R10 R7 R2: read three bytes from pointer 0
    bus_start();
    wbyte({ADDR, 1'b1}, ack);
    chk(ack == 1'b0, "R3 read address acknowledged", ack, 0);
    rd(stat0, "R9 R2 signal-detect byte", 1'b0);
    rd(8'h00, "R10 receiver byte zero while not valid", 1'b0);
    rd(8'h00, "R7 control byte 2 follows", 1'b1);
    bus_stop();

    // R4 R5: pointer now 3, filler then one byte
    bus_start();
    wbyte({ADDR, 1'b0}, ack);
    chk(ack == 1'b0, "R3 write address acknowledged", ack, 0);
    wbyte(8'hEE, ack);
    chk(ack == 1'b0, "R3 filler acknowledged", ack, 0);
    wbyte(8'h77, ack);
    chk(ack == 1'b0, "R3 data acknowledged", ack, 0);
    bus_stop();
    wt(5);
    chk(ctrl_q == 16'h7700, "R4 R5 filler dropped, byte at pointer 3", ctrl_q, 16'h7700);

    // R6 R5: pointer back at 0, write through read-only bytes
    bus_start();
    wbyte({ADDR, 1'b0}, ack);
    wbyte(8'h99, ack);
    wbyte(8'h12, ack);
    wbyte(8'h34, ack);
    wbyte(8'h3C, ack);
    wbyte(8'hA5, ack);
    chk(ack == 1'b0, "R3 last write byte acknowledged", ack, 0);
    bus_stop();
    wt(5);
    chk(ctrl_q == 16'hA53C, "R5 R6 block write from byte 0", ctrl_q, 16'hA53C);

    // R7: five reads from 0, wrapping
    bus_start();
    wbyte({ADDR, 1'b1}, ack);
    rd(stat0, "R5 read-only byte 0 unchanged by write", 1'b0);
    rd(8'h00, "R10 byte 1 unchanged", 1'b0);
    rd(8'h3C, "R7 byte 2", 1'b0);
    rd(8'hA5, "R7 byte 3", 1'b0);
    rd(stat0, "R7 wrap to byte 0", 1'b1);
    bus_stop();
    wt(2);
    chk(sda_oe == 1'b0, "R8 NACK ends read", sda_oe, 0);

    // R10: valid receiver results, pointer continues at 1
    rxd_a = 4'b1000; rxd_b = 4'b0001; rxd_valid = 1'b1;
    bus_start();
    wbyte({ADDR, 1'b1}, ack);
    rd(pack_ch(rxd_a, rxd_b), "R10 R7 receiver byte 0x42", 1'b1);
    bus_stop();

    // R6 R12: write at pointer 2, repeated START into a read
    bus_start();
    wbyte({ADDR, 1'b0}, ack);
    wbyte(8'h00, ack);
    wbyte(8'h55, ack);
    bus_start();
    wbyte({ADDR, 1'b1}, ack);
    chk(ack == 1'b0, "R12 repeated START restarts decode", ack, 0);
    rd(stat0, "R6 pointer 0 after repeated START", 1'b1);
    bus_stop();
    wt(5);
    chk(ctrl_q == 16'hA555, "R5 byte 2 written", ctrl_q, 16'hA555);

    // R12: STOP inside the address byte
    bus_start();
    wbit(ADDR[6]); wbit(ADDR[5]); wbit(ADDR[4]); wbit(ADDR[3]);
    bus_stop();
    wt(2);
    chk(sda_oe == 1'b0, "R12 STOP mid-byte leaves SDA free", sda_oe, 0);
    bus_start();
    wbyte({ADDR, 1'b1}, ack);
    chk(ack == 1'b0, "R12 next transaction after abort", ack, 0);
    rd(pack_ch(rxd_a, rxd_b), "R7 pointer kept by read", 1'b1);
    bus_stop();

    wt(20);
    chk(exp_q.size() == 0, "R7 all reads compared", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule